// File: doc/BRIEF.md
# Four-Channel Square-Wave Tone Generator

This block produces a mixed digital audio sample from four independent square-wave voices. Software programs it through a small I/O write port: one 16-bit half-period register per voice, and two shared registers that each carry the 8-bit loudness of two voices. A per-cycle enable paces the voice counters, so the pitch scale is set by how often that enable is high.

Each voice runs a 16-bit down-counter. When the count sits at zero it reloads from the voice's half-period register. When it steps from one to zero, the voice's polarity flips. A half-period value of zero mutes the tone: the polarity stays positive. The mixer weights each voice as plus or minus its loudness, depending on its polarity, adds the four terms, and registers the sum as a signed 18-bit sample.

Top module: `quad_tone_gen`

## Requirements
- R1: After reset, every half-period and loudness register is 0, every counter is 0, every polarity is positive, and the sample reads 0.
- R2: A write to any port address other than 4 to 9 leaves all voices and the sample unchanged.
- R3: A write to port 8 sets voice 0's loudness from data bits 15:8 and voice 1's from bits 7:0. A write to port 9 does the same for voices 2 and 3.
- R4: A write to port 4+k (k = 0..3) sets voice k's half-period register. On an enabled cycle where a voice's count is 0, the count loads from that register. On other enabled cycles the count decrements by one.
- R5: A voice's polarity flips on the enabled cycle in which its count goes from 1 to 0. With half-period value P > 0, this gives a flip every P+1 enabled cycles.
- R6: While a voice's half-period register is 0, its polarity is forced positive on every enabled cycle.
- R7: On cycles with the enable low, no counter and no polarity changes.
- R8: Rewriting a half-period register does not disturb the running count. The new value is first used at the next reload.
- R9: The sample is the signed sum of +loudness for positive voices and −loudness for negative voices. It is registered one clock after the polarities and loudnesses it reflects, and always lies within ±1020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| io_wr | input | 1 | Write strobe for the I/O port |
| io_addr | input | 4 | Port address of the write |
| io_wdata | input | 16 | Write data |
| mix_sample | output | 18 | Signed mixed sample, two's complement |

## Verification
The hardest cases to reach from the ports are those where register writes land in the middle of a half-period. One is a half-period rewrite while a count is running. The other is a voice silenced to zero while its counter is still non-zero. Both show up only as a shift in later flip timing or as a polarity pinned positive.

The stimulus sets the four loudnesses to 8, 4, 2 and 1. With these weights every combination of polarities gives a distinct sample, so each voice's state can be read back through the single output. The voices run with unrelated half-periods, and the stimulus writes new values mid-count, both under a continuous enable and under a sparse one. A bench model of the counters predicts each sample.

// File: rtl/snd_pkg.sv
package snd_pkg;
  localparam int SND_NCH       = 4;
  localparam int SND_CNT_W     = 16;
  localparam int SND_VOL_W     = 8;
  localparam int SND_DATA_W    = 16;
  localparam int SND_SAMPLE_W  = 18;
  localparam int SND_ADDR_W    = 4;
  localparam int SND_FREQ_BASE = 4;
  localparam int SND_VOL_BASE  = 8;

  // largest magnitude the mixed sample can reach
  function automatic int max_swing(input int nch, input int vol_w);
    return nch * ((1 << vol_w) - 1);
  endfunction
endpackage

// File: rtl/snd_port_regs.sv
module snd_port_regs #(
  parameter int NCH       = snd_pkg::SND_NCH,
  parameter int CNT_W     = snd_pkg::SND_CNT_W,
  parameter int VOL_W     = snd_pkg::SND_VOL_W,
  parameter int DATA_W    = snd_pkg::SND_DATA_W,
  parameter int ADDR_W    = snd_pkg::SND_ADDR_W,
  parameter int FREQ_BASE = snd_pkg::SND_FREQ_BASE,
  parameter int VOL_BASE  = snd_pkg::SND_VOL_BASE
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [NCH-1:0][CNT_W-1:0]  period,
  output logic [NCH-1:0][VOL_W-1:0]  vol
);
  localparam int NVP = NCH / 2;

  logic [NCH-1:0]             freq_hit;
  logic [NVP-1:0]             vol_hit;
  logic                       any_hit;
  logic [NCH-1:0][CNT_W-1:0]  period_q;
  logic [NCH-1:0][VOL_W-1:0]  vol_q;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_fdec
      assign freq_hit[g] = wr && (addr == ADDR_W'(FREQ_BASE + g));
    end
    for (g = 0; g < NVP; g++) begin : g_vdec
      assign vol_hit[g] = wr && (addr == ADDR_W'(VOL_BASE + g));
    end
  endgenerate

  assign any_hit = (|freq_hit) || (|vol_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= '0;
      vol_q    <= '0;
    end else begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (freq_hit[ch]) period_q[ch] <= wdata[CNT_W-1:0];
        if (vol_hit[ch/2]) begin
          if ((ch % 2) == 0) vol_q[ch] <= wdata[DATA_W-1 -: VOL_W];
          else               vol_q[ch] <= wdata[VOL_W-1:0];
        end
      end
    end
  end

  assign period = period_q;
  assign vol    = vol_q;

  // R2: a write that decodes to no register changes nothing
  assert_stray_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !any_hit) |=> ($stable(period_q) && $stable(vol_q)));

  // R3/R4: at most one register group is selected per write
  assert_single_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({freq_hit, vol_hit}));
endmodule

// File: rtl/snd_tone_chan.sv
module snd_tone_chan #(
  parameter int CNT_W = snd_pkg::SND_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             pol
);
  logic [CNT_W-1:0] cnt_q;
  logic             pol_q;
  logic             at_zero;
  logic             last_step;
  logic             silent;

  assign at_zero   = (cnt_q == '0);
  assign last_step = tick && (cnt_q == CNT_W'(1));
  assign silent    = (period == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= 1'b1;
    end else if (tick) begin
      cnt_q <= at_zero ? period : cnt_q - CNT_W'(1);
      if (silent)         pol_q <= 1'b1;
      else if (last_step) pol_q <= ~pol_q;
    end
  end

  assign pol = pol_q;

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && at_zero) |=> (cnt_q == $past(period)));

  // R8: a running count keeps stepping down whatever is written
  assert_count_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !at_zero) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (last_step && !silent) |=> (pol_q != $past(pol_q)));

  assert_mute_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && silent) |=> pol_q);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(cnt_q) && $stable(pol_q)));
endmodule

// File: rtl/snd_mixer.sv
module snd_mixer #(
  parameter int NCH      = snd_pkg::SND_NCH,
  parameter int VOL_W    = snd_pkg::SND_VOL_W,
  parameter int SAMPLE_W = snd_pkg::SND_SAMPLE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NCH-1:0]            pol,
  input  logic [NCH-1:0][VOL_W-1:0] vol,
  output logic [SAMPLE_W-1:0]       sample
);
  localparam int SWING = snd_pkg::max_swing(NCH, VOL_W);

  function automatic logic signed [SAMPLE_W-1:0] term_of(
    input logic p, input logic [VOL_W-1:0] v);
    logic signed [SAMPLE_W-1:0] mag;
    mag = $signed({{(SAMPLE_W-VOL_W){1'b0}}, v});
    return p ? mag : -mag;
  endfunction

  logic signed [SAMPLE_W-1:0] acc;
  logic signed [SAMPLE_W-1:0] sample_q;

  always_comb begin
    acc = '0;
    for (int i = 0; i < NCH; i++) acc = acc + term_of(pol[i], vol[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sample_q <= '0;
    else        sample_q <= acc;
  end

  assign sample = sample_q;

  assert_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_q <= SAMPLE_W'(SWING)) && (sample_q >= -SAMPLE_W'(SWING)));

  assert_all_pos_nonneg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (&pol) |=> !sample_q[SAMPLE_W-1]);
endmodule

// File: rtl/quad_tone_gen.sv
module quad_tone_gen #(
  parameter int NCH       = snd_pkg::SND_NCH,
  parameter int CNT_W     = snd_pkg::SND_CNT_W,
  parameter int VOL_W     = snd_pkg::SND_VOL_W,
  parameter int DATA_W    = snd_pkg::SND_DATA_W,
  parameter int ADDR_W    = snd_pkg::SND_ADDR_W,
  parameter int SAMPLE_W  = snd_pkg::SND_SAMPLE_W,
  parameter int FREQ_BASE = snd_pkg::SND_FREQ_BASE,
  parameter int VOL_BASE  = snd_pkg::SND_VOL_BASE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_en,
  input  logic                io_wr,
  input  logic [ADDR_W-1:0]   io_addr,
  input  logic [DATA_W-1:0]   io_wdata,
  output logic [SAMPLE_W-1:0] mix_sample
);
  logic [NCH-1:0][CNT_W-1:0] period;
  logic [NCH-1:0][VOL_W-1:0] vol;
  logic [NCH-1:0]            pol;

  snd_port_regs #(
    .NCH(NCH), .CNT_W(CNT_W), .VOL_W(VOL_W), .DATA_W(DATA_W),
    .ADDR_W(ADDR_W), .FREQ_BASE(FREQ_BASE), .VOL_BASE(VOL_BASE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(io_wr), .addr(io_addr),
    .wdata(io_wdata), .period(period), .vol(vol)
  );

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_voice
      snd_tone_chan #(.CNT_W(CNT_W)) u_chan (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .period(period[g]), .pol(pol[g])
      );
    end
  endgenerate

  snd_mixer #(.NCH(NCH), .VOL_W(VOL_W), .SAMPLE_W(SAMPLE_W)) u_mix (
    .clk(clk), .rst_n(rst_n), .pol(pol), .vol(vol), .sample(mix_sample)
  );

  // R1: right after reset is released every voice is positive and silent
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mix_sample == '0));
endmodule

// File: tb/tb_quad_tone_gen.sv
module tb_quad_tone_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        io_wr = 1'b0;
  logic [3:0]  io_addr = '0;
  logic [15:0] io_wdata = '0;
  logic [17:0] mix_sample;

  always #5 clk = ~clk;

  quad_tone_gen dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .io_wr(io_wr),
    .io_addr(io_addr), .io_wdata(io_wdata), .mix_sample(mix_sample)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_tag = "R1";
  int    exp_q[$];
  string tag_q[$];

  // independent reference model, written from the requirements
  int m_cnt[4];
  int m_per[4];
  int m_vol[4];
  bit m_pol[4];

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver side: predict the sample each edge produces and queue it
  always @(posedge clk) begin
    int e;
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_cnt[c] = 0; m_per[c] = 0; m_vol[c] = 0; m_pol[c] = 1'b1;
      end
    end else begin
      e = 0;
      for (int c = 0; c < 4; c++) e += m_pol[c] ? m_vol[c] : -m_vol[c];
      exp_q.push_back(e);
      tag_q.push_back(cur_tag);
      if (tick_en) begin
        for (int c = 0; c < 4; c++) begin
          if (m_cnt[c] == 0) m_cnt[c] = m_per[c];
          else begin
            if (m_cnt[c] == 1) m_pol[c] = ~m_pol[c];
            m_cnt[c] = m_cnt[c] - 1;
          end
          if (m_per[c] == 0) m_pol[c] = 1'b1;
        end
      end
      if (io_wr) begin
        if (io_addr >= 4 && io_addr <= 7) m_per[io_addr-4] = int'(io_wdata);
        else if (io_addr == 8) begin
          m_vol[0] = int'(io_wdata[15:8]); m_vol[1] = int'(io_wdata[7:0]);
        end else if (io_addr == 9) begin
          m_vol[2] = int'(io_wdata[15:8]); m_vol[3] = int'(io_wdata[7:0]);
        end
      end
    end
  end

  // monitor side: pop and compare away from the active edge
  always @(negedge clk) begin
    int e;
    string t;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, int'($signed(mix_sample)), e);
    end
  end

  task automatic io_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_en = ((i % every) == 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sample", int'($signed(mix_sample)), 0);
    rst_n = 1'b1;
    run(4, 1);
    // R3: weights 8/4/2/1 make each voice visible; R6 all periods zero
    cur_tag = "R3";
    io_write(4'd8, 16'h0804);
    io_write(4'd9, 16'h0201);
    cur_tag = "R6";
    run(6, 1);
    // R4/R5/R9: free running with unrelated half-periods
    cur_tag = "R5";
    io_write(4'd4, 16'd2);
    io_write(4'd5, 16'd3);
    io_write(4'd6, 16'd5);
    io_write(4'd7, 16'd7);
    run(60, 1);
    // R7: sparse enable
    cur_tag = "R7";
    run(45, 3);
    // R8: mid-count rewrite
    cur_tag = "R8";
    io_write(4'd4, 16'd6);
    io_write(4'd7, 16'd1);
    run(40, 1);
    // R2: stray ports
    cur_tag = "R2";
    io_write(4'd3, 16'h0000);
    io_write(4'd10, 16'hFFFF);
    io_write(4'd15, 16'h1234);
    io_write(4'd0, 16'h0005);
    run(20, 1);
    // R6: silence a voice while its count is running
    cur_tag = "R6";
    io_write(4'd6, 16'd0);
    run(25, 2);
    // R9: full loudness, extremes of the sum
    cur_tag = "R9";
    io_write(4'd8, 16'hFFFF);
    io_write(4'd9, 16'hFFFF);
    io_write(4'd6, 16'd4);
    run(40, 1);
    // R4: long half-period reload
    cur_tag = "R4";
    io_write(4'd5, 16'd20);
    run(50, 1);
    tick_en = 1'b0;
    run(3, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule